// File: doc/BRIEF.md
# Layered-Reset Control Register Bank

This block holds the control registers of an audio receiver and turns three layered reset sources into the reset and gating signals of the neighbouring sections. The outermost source is an asynchronous active-low power-down pin. It is synchronised to the system clock and, while low, wipes the whole bank and holds every downstream section in reset. Inside the bank, register 0 carries two power-control bits. A run bit acts as a soft reset. A clock-recovery enable acts as a partial power-down.

Clearing the run bit puts every other register back to its default and holds the internal timing in reset. It also forces the serial data output low and blocks every access except writes to register 0. The recovered clocks keep running through this. Clearing the clock-recovery enable resets only the recovery section and stops its clocks. Register contents and register access are not affected. Software reaches the bank through a simple synchronous port with a write strobe, a read strobe and a registered read-data bus.

Top module: `audio_rst_regbank`

## Requirements
- R1: While `pdn_n` is low, `clkrec_rst_n` and `timing_rst_n` are 0 and `sdo_hold_low` is 1, from the moment the pin falls. The bank returns to its default contents.
- R2: While `pdn_n` is low, or during the two clock edges after it rises, writes have no effect and `rdata` is 0.
- R3: After `pdn_n` is released, both power-control bits are 0. Each section stays in reset until a write of 1 to its bit.
- R4: Register 0 holds the run bit at bit 0 and the clock-recovery enable at bit 1. Writes to register 0 store only those two bits, and reads return bits 7..2 as 0.
- R5: While the run bit is 0, `timing_rst_n` is 0 and `sdo_hold_low` is 1, and `clkrec_rst_n` still follows the clock-recovery enable. While the run bit is 1, `timing_rst_n` is 1 and `sdo_hold_low` is 0.
- R6: While the run bit is 0, registers 1 to 5 are held at their defaults and writes to them are dropped. Writes to register 0 are still accepted.
- R7: While the run bit is 0, every read returns 0, including a read of register 0.
- R8: While the clock-recovery enable is 0, `clkrec_rst_n` is 0, and register contents, reads and writes are unaffected.
- R9: Register 1 resets to 0x01, where bit 0 is the de-emphasis automatic-mode bit. Registers 2 to 5 reset to 0x00. All eight bits of registers 1 to 5 can be written.
- R10: Addresses 6 and 7 are unimplemented. Writes to them are ignored, and reads from them return 0.
- R11: `rdata` shows the addressed register one clock after a cycle with `rd_en` high, and shows 0 one clock after any cycle with `rd_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pdn_n | input | 1 | Asynchronous active-low power-down pin |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, sampled on the clock edge |
| rd_en | input | 1 | Read strobe, sampled on the clock edge |
| rdata | output | 8 | Registered read data |
| clkrec_rst_n | output | 1 | Active-low reset of the clock-recovery section |
| timing_rst_n | output | 1 | Active-low reset of the internal timing |
| sdo_hold_low | output | 1 | Forces the serial data output low when 1 |

## Verification
The bench builds the bank with its default parameters: eight 8-bit addresses, six of them implemented, and a two-stage pin synchroniser. At this size the bench can write every one of the 256 data values to every address, including register 0. So the soft-reset and partial power-down states are entered and left many times in the middle of the sweep. The expected read value and the three reset outputs are predicted from a small arithmetic model after each access. Separate sequences exercise the power-down pin and the synchroniser release window.

// File: rtl/regbank_pkg.sv
// Package: shared sizes and reset values of the control register bank.
// Assumes: register 1 carries the de-emphasis automatic-mode bit in bit 0.
package regbank_pkg;
    localparam int DEEMPH_ADDR = 1;
    localparam int RUN_BIT     = 0;
    localparam int CLKREC_BIT  = 1;
    localparam int PWR_BITS    = 2;

    // Reset value of an implemented data register (register 0 excluded).
    function automatic logic [7:0] reg_default(input int idx);
        return (idx == DEEMPH_ADDR) ? 8'h01 : 8'h00;
    endfunction
endpackage

// File: rtl/pdn_sync.sv
// Module: synchroniser for the power-down pin.
// The pin asserts the reset at once and releases it only after SYNC_STAGES
// clock edges. Assumes pdn_n may change at any time relative to clk.
module pdn_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic pdn_n,
    output logic sys_rst_n
);
    logic [SYNC_STAGES-1:0] stage_q;

    // Shift ones in after release; clear all stages as soon as the pin falls.
    always_ff @(posedge clk or negedge pdn_n) begin
        if (!pdn_n) stage_q <= '0;
        else        stage_q <= {stage_q[SYNC_STAGES-2:0], 1'b1};
    end

    assign sys_rst_n = stage_q[SYNC_STAGES-1];
endmodule

// File: rtl/ctrl_regfile.sv
// Module: register storage, access gating and registered read port.
// Register 0 holds the two power-control bits. Registers 1..NUM_IMPL-1 are
// plain data registers. Addresses at or above NUM_IMPL are unimplemented.
// Assumes: sys_rst_n is a synchronous active-low reset, already synchronised.
module ctrl_regfile
    import regbank_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 8,
    parameter int NUM_IMPL = 6,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                sys_rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                wr_en,
    input  logic                rd_en,
    output logic [DATA_W-1:0]   rdata,
    output logic [PWR_BITS-1:0] pwr_q
);
    logic [NUM_IMPL*DATA_W-1:0] rd_bus;
    logic                       run;
    logic                       addr_impl;

    assign run       = pwr_q[RUN_BIT];
    assign addr_impl = int'(addr) < NUM_IMPL;

    // Power-control bits: cleared only by the pin, always writable otherwise.
    always_ff @(posedge clk) begin
        if (!sys_rst_n)
            pwr_q <= '0;
        else if (wr_en && addr == '0)
            pwr_q <= wdata[PWR_BITS-1:0];
    end

    for (genvar i = 0; i < NUM_IMPL; i++) begin : g_reg
        if (i == 0) begin : g_pwr
            assign rd_bus[i*DATA_W +: DATA_W] = {{(DATA_W-PWR_BITS){1'b0}}, pwr_q};
        end else begin : g_data
            logic [DATA_W-1:0] q;
            // Data register: held at default by pin or soft reset, else writable.
            always_ff @(posedge clk) begin
                if (!sys_rst_n || !run)
                    q <= DATA_W'(reg_default(i));
                else if (wr_en && addr == ADDR_W'(i))
                    q <= wdata;
            end
            assign rd_bus[i*DATA_W +: DATA_W] = q;
        end
    end

    // Read port: one-cycle latency, zero when idle, blocked or unimplemented.
    always_ff @(posedge clk) begin
        if (!sys_rst_n)
            rdata <= '0;
        else if (rd_en && run && addr_impl)
            rdata <= rd_bus[int'(addr)*DATA_W +: DATA_W];
        else
            rdata <= '0;
    end
endmodule

// File: rtl/rst_outputs.sv
// Module: derives the section resets and the data-output gate.
// The pin-level reset overrides both register bits so the outputs assert
// as soon as the synchronised reset falls.
module rst_outputs
    import regbank_pkg::*;
(
    input  logic                sys_rst_n,
    input  logic [PWR_BITS-1:0] pwr_q,
    output logic                clkrec_rst_n,
    output logic                timing_rst_n,
    output logic                sdo_hold_low
);
    // Combine the pin reset with each section's enable bit.
    always_comb begin
        clkrec_rst_n = sys_rst_n & pwr_q[CLKREC_BIT];
        timing_rst_n = sys_rst_n & pwr_q[RUN_BIT];
        sdo_hold_low = ~(sys_rst_n & pwr_q[RUN_BIT]);
    end
endmodule

// File: rtl/audio_rst_regbank.sv
// Module: top of the layered-reset control register bank.
// Joins the pin synchroniser, the register file and the reset output logic.
// Assumes a single system clock that runs whenever the pin is high.
module audio_rst_regbank
    import regbank_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int NUM_REGS    = 8,
    parameter int NUM_IMPL    = 6,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W     = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              pdn_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    output logic              clkrec_rst_n,
    output logic              timing_rst_n,
    output logic              sdo_hold_low
);
    logic                sys_rst_n;
    logic [PWR_BITS-1:0] pwr_q;

    pdn_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .pdn_n    (pdn_n),
        .sys_rst_n(sys_rst_n)
    );

    ctrl_regfile #(
        .DATA_W  (DATA_W),
        .NUM_REGS(NUM_REGS),
        .NUM_IMPL(NUM_IMPL)
    ) u_regs (
        .clk      (clk),
        .sys_rst_n(sys_rst_n),
        .addr     (addr),
        .wdata    (wdata),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .rdata    (rdata),
        .pwr_q    (pwr_q)
    );

    rst_outputs u_outs (
        .sys_rst_n   (sys_rst_n),
        .pwr_q       (pwr_q),
        .clkrec_rst_n(clkrec_rst_n),
        .timing_rst_n(timing_rst_n),
        .sdo_hold_low(sdo_hold_low)
    );
endmodule

// File: rtl/audio_rst_regbank_chk.sv
// Module: port-level assertion checker for audio_rst_regbank, bound below.
module audio_rst_regbank_chk #(
    parameter int DATA_W   = 8,
    parameter int NUM_IMPL = 6,
    parameter int ADDR_W   = 3
) (
    input logic              clk,
    input logic              pdn_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] rdata,
    input logic              clkrec_rst_n,
    input logic              timing_rst_n,
    input logic              sdo_hold_low
);
    AST_PIN_HOLDS_RESETS: assert property (@(posedge clk)
        !pdn_n |-> (!clkrec_rst_n && !timing_rst_n && sdo_hold_low)); // R1
    AST_GATE_TRACKS_TIMING: assert property (@(posedge clk) disable iff (!pdn_n)
        sdo_hold_low == !timing_rst_n); // R5
    AST_SOFT_BLOCKS_READ: assert property (@(posedge clk) disable iff (!pdn_n)
        !timing_rst_n |=> rdata == '0); // R7
    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!pdn_n)
        !rd_en |=> rdata == '0); // R11
    AST_UNIMPL_READ_ZERO: assert property (@(posedge clk) disable iff (!pdn_n)
        (rd_en && int'(addr) >= NUM_IMPL) |=> rdata == '0); // R10
    AST_REG0_UPPER_ZERO: assert property (@(posedge clk) disable iff (!pdn_n)
        (rd_en && addr == '0) |=> rdata[DATA_W-1:2] == '0); // R4
    AST_CLKREC_WRITE_ONLY: assert property (@(posedge clk) disable iff (!pdn_n)
        !(wr_en && addr == '0) |=> $stable(clkrec_rst_n)); // R8
endmodule

bind audio_rst_regbank audio_rst_regbank_chk #(
    .DATA_W  (DATA_W),
    .NUM_IMPL(NUM_IMPL),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk         (clk),
    .pdn_n       (pdn_n),
    .addr        (addr),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .rdata       (rdata),
    .clkrec_rst_n(clkrec_rst_n),
    .timing_rst_n(timing_rst_n),
    .sdo_hold_low(sdo_hold_low)
);

// File: tb/test_audio_rst_regbank.sv
// Bench: exhaustive write/read sweep plus power-down pin sequences.
module test_audio_rst_regbank;
    logic       clk = 1'b0;
    logic       pdn_n = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic       clkrec_rst_n, timing_rst_n, sdo_hold_low;

    int checks = 0;
    int errors = 0;
    logic [7:0] mdl [8];

    always #5 clk = ~clk;

    audio_rst_regbank i_audio_rst_regbank (
        .clk(clk), .pdn_n(pdn_n), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
        .clkrec_rst_n(clkrec_rst_n), .timing_rst_n(timing_rst_n),
        .sdo_hold_low(sdo_hold_low)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk); addr = 3'(a); wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        @(negedge clk); addr = 3'(a); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    // Model reset defaults of the bank (R9).
    task automatic mdl_defaults(input bit with_pwr);
        for (int i = 1; i < 8; i++) mdl[i] = (i == 1) ? 8'h01 : 8'h00;
        if (with_pwr) mdl[0] = 8'h00;
    endtask

    function automatic logic [7:0] mdl_read(input int a);
        if (!mdl[0][0] || a >= 6) return 8'h00;
        return mdl[a];
    endfunction

    task automatic mdl_write(input int a, input logic [7:0] d);
        if (a == 0) begin
            mdl[0] = {6'b0, d[1:0]};
            if (!d[0]) mdl_defaults(1'b0);
        end else if (a < 6 && mdl[0][0]) begin
            mdl[a] = d;
        end
    endtask

    task automatic check_outs(input string req);
        check({req, " clkrec"}, {7'b0, clkrec_rst_n}, {7'b0, mdl[0][1]});
        check({req, " timing"}, {7'b0, timing_rst_n}, {7'b0, mdl[0][0]});
        check({req, " gate"},   {7'b0, sdo_hold_low}, {7'b0, ~mdl[0][0]});
    endtask

    initial begin : watchdog
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [7:0] d;
        mdl_defaults(1'b1);
        repeat (3) @(negedge clk);
        // R1: pin low holds every output in reset.
        check("R1 clkrec", {7'b0, clkrec_rst_n}, 8'h00);
        check("R1 timing", {7'b0, timing_rst_n}, 8'h00);
        check("R1 gate",   {7'b0, sdo_hold_low}, 8'h01);
        // R2: write and read while pin low are ignored.
        wr(0, 8'h03);
        rd(1, d); check("R2 read during pin low", d, 8'h00);
        pdn_n = 1'b1;
        // R2: write inside the release window (second edge) is still dropped.
        @(negedge clk); addr = 3'd0; wdata = 8'h03; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        repeat (2) @(negedge clk);
        // R3: both power bits still 0 after release.
        check_outs("R3 after release");
        wr(0, 8'h01); mdl_write(0, 8'h01);
        check_outs("R3 run only");
        // R9: defaults visible.
        rd(1, d); check("R9 reg1 default", d, 8'h01);
        rd(2, d); check("R9 reg2 default", d, 8'h00);
        // R11: rdata zero on an idle cycle after a read.
        @(negedge clk); check("R11 idle rdata", rdata, 8'h00);
        // R4..R10: every value to every address, read back all addresses.
        for (int a = 0; a < 8; a++) begin
            for (int v = 0; v < 256; v++) begin
                wr(a, 8'(v)); mdl_write(a, 8'(v));
                check_outs("R5 R8 outputs");
                rd(a, d);
                if (a == 0)       check("R4 R7 reg0 readback", d, mdl_read(a));
                else if (a >= 6)  check("R10 unimplemented", d, mdl_read(a));
                else              check("R6 R9 data readback", d, mdl_read(a));
            end
            wr(0, 8'h03); mdl_write(0, 8'h03);
            for (int b = 0; b < 8; b++) begin
                rd(b, d); check("R6 R10 sweep read", d, mdl_read(b));
            end
        end
        // R8: clock-recovery off keeps contents and access.
        wr(3, 8'hA5); mdl_write(3, 8'hA5);
        wr(0, 8'h01); mdl_write(0, 8'h01);
        check_outs("R8 clkrec off");
        wr(4, 8'h5A); mdl_write(4, 8'h5A);
        rd(3, d); check("R8 kept", d, 8'hA5);
        rd(4, d); check("R8 write ok", d, 8'h5A);
        // R6 R7: soft reset, write ignored, defaults restored.
        wr(0, 8'h02); mdl_write(0, 8'h02);
        check_outs("R5 soft reset");
        wr(2, 8'h77); mdl_write(2, 8'h77);
        rd(0, d); check("R7 reg0 blocked", d, 8'h00);
        wr(0, 8'h03); mdl_write(0, 8'h03);
        rd(2, d); check("R6 write dropped", d, 8'h00);
        rd(3, d); check("R6 cleared", d, 8'h00);
        rd(1, d); check("R9 reg1 restored", d, 8'h01);
        // R1: pin falls mid-run; outputs drop before any clock edge.
        wr(5, 8'h44);
        @(negedge clk); #2 pdn_n = 1'b0; #1;
        check("R1 async clkrec", {7'b0, clkrec_rst_n}, 8'h00);
        check("R1 async gate",   {7'b0, sdo_hold_low}, 8'h01);
        repeat (2) @(negedge clk);
        pdn_n = 1'b1;
        repeat (3) @(negedge clk);
        mdl_defaults(1'b1);
        check_outs("R3 second release");
        wr(0, 8'h03); mdl_write(0, 8'h03);
        rd(5, d); check("R1 bank cleared", d, 8'h00);
        rd(1, d); check("R1 reg1 default", d, 8'h01);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule